// File: doc/BRIEF.md
# Serial Receiver with Status FIFO

This block turns an asynchronous serial line into parallel characters. It is paced by a tick input that pulses a fixed number of times per bit period. The tick comes from a baud generator outside the block, and the number of ticks per bit is the parameter `OVS`, 16 by default. A valid character goes into a first-in first-out buffer, 16 entries deep by default. Each entry keeps its own parity-error and frame-error flags beside the data byte, so an error stays tied to the character that caused it.

Software, or a bus decoder outside the block, reads the buffer through a one-cycle read strobe and a 10-bit read word. It also sees three status outputs:
- a not-empty flag;
- a half-full flag;
- a sticky overrun flag.

An interrupt contribution combines not-empty and overrun. The frame format is chosen by a 3-bit format code and a parity-polarity bit. Reception runs only while both the receive-enable input and the run input are high. A synchronous clear input empties the buffer.

Top module: `serial_rx_stat`

## Requirements
- R1: The format code selects the frame. Code 1 is 8 data bits with no parity bit. Code 3 is 7 data bits followed by a parity bit, and bit 7 of the read word then reads 0. Code 7 is 8 data bits followed by a parity bit. Any other code behaves as code 1. Every frame is one low start bit, data least-significant bit first, the optional parity bit, then a stop bit.
- R2: The read word carries the data in bits 7:0, the parity-error flag in bit 8 and the frame-error flag in bit 9.
- R3: With odd_par high, the count of ones over the data bits and the parity bit must be odd; with odd_par low it must be even. A mismatch sets bit 8. Under code 1 (and the codes treated as code 1) bit 8 is always 0.
- R4: A start bit is accepted only if the line is still low at mid-bit, OVS/2 ticks after the falling edge is seen. A low pulse shorter than about half a bit stores nothing.
- R5: A low stop bit sets bit 9. An all-zero frame with a low stop bit (a break) reads 0x200. After a low stop bit the receiver waits for the line to go high before it looks for a new start bit, so a long low period stores exactly one entry.
- R6: Characters are received only while rx_en and run are both 1. A frame sent while either is 0 stores nothing.
- R7: Entries are read in arrival order. A read strobe while the buffer is non-empty removes the head entry. rd_word is 0 while the buffer is empty, and stat_nonempty is 1 whenever at least one entry is held.
- R8: stat_half is 1 while the buffer holds at least DEPTH/2 entries.
- R9: A character that completes while the buffer is full is discarded and sets stat_ovr. stat_ovr stays set until a read strobe removes an entry.
- R10: fifo_clr empties the buffer and clears stat_ovr in the next cycle. It takes priority over a character arriving in the same cycle.
- R11: rx_irq is 1 exactly when stat_nonempty or stat_ovr is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_in | input | 1 | Serial line, idle high |
| tick | input | 1 | Oversampling tick, OVS pulses per bit period |
| fmt | input | 3 | Frame format code |
| odd_par | input | 1 | 1 selects odd parity, 0 selects even parity |
| rx_en | input | 1 | Receive enable |
| run | input | 1 | Run enable; must also be high for reception |
| fifo_clr | input | 1 | Synchronous buffer clear |
| rd_stb | input | 1 | Read strobe; removes the head entry |
| rd_word | output | 10 | Head entry: {frame error, parity error, data} |
| stat_nonempty | output | 1 | Buffer holds at least one entry |
| stat_half | output | 1 | Buffer holds at least DEPTH/2 entries |
| stat_ovr | output | 1 | Sticky overrun flag |
| rx_irq | output | 1 | Interrupt contribution |

## Verification
The bench uses the default parameters: OVS of 16, DEPTH of 16 and two synchronizer stages. It pulses tick every other clock, so one bit lasts 32 clocks. With that depth, sixteen frames sent with no reads fill the buffer, and a seventeenth drives the overrun path. The half-full threshold is crossed between the seventh and the eighth entry. Bit periods of 32 clocks leave a wide margin for the start-bit check, which lets a short glitch be rejected while genuine frames sampled near mid-bit are kept.

// File: rtl/serrx_pkg.sv
package serrx_pkg;
    localparam int DATA_W = 8;

    // Frame format codes; decoded by the sampler.
    localparam logic [2:0] FMT_8N = 3'd1;
    localparam logic [2:0] FMT_7P = 3'd3;
    localparam logic [2:0] FMT_8P = 3'd7;

    // One buffer entry; the field order fixes the read word layout.
    typedef struct packed {
        logic              ferr;
        logic              perr;
        logic [DATA_W-1:0] data;
    } rx_word_t;

    localparam int WORD_W = $bits(rx_word_t);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_HOLD
    } rx_state_e;
endpackage

// File: rtl/serrx_sync.sv
module serrx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_d, sh_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb sh_d = d;
        end else begin : g_chain
            always_comb sh_d = {sh_q[STAGES-2:0], d};
        end
    endgenerate

    // Reset to the idle-high line level.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/serrx_sampler.sv
module serrx_sampler
    import serrx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     active,
    input  logic     tick,
    input  logic     rx_s,
    input  logic [2:0] fmt,
    input  logic     odd_par,
    output logic     frame_vld,
    output rx_word_t frame_word
);
    localparam int CW = (OVS > 2) ? $clog2(OVS) : 1;
    localparam int BW = $clog2(DATA_W + 1);
    localparam logic [CW-1:0] CNT_MID  = CW'(OVS/2 - 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(OVS - 1);
    localparam logic [BW-1:0] BIT_L8   = BW'(DATA_W - 1);
    localparam logic [BW-1:0] BIT_L7   = BW'(DATA_W - 2);

    typedef struct packed {
        rx_state_e         state;
        logic [CW-1:0]     cnt;
        logic [BW-1:0]     nbit;
        logic [DATA_W-1:0] sh;
        logic              acc;
        logic              seven;
        logic              use_par;
        logic              odd;
        logic              vld;
        rx_word_t          word;
    } smp_t;

    localparam smp_t SMP_RST = '{state: ST_IDLE, default: '0};

    smp_t q, d;

    always_comb begin
        d     = q;
        d.vld = 1'b0;
        if (!active) begin
            d.state = ST_IDLE;
            d.cnt   = '0;
        end else begin
            case (q.state)
                ST_IDLE: begin
                    if (tick && !rx_s) begin
                        d.state = ST_START;
                        d.cnt   = '0;
                    end
                end
                ST_START: begin
                    if (tick) begin
                        if (q.cnt == CNT_MID) begin
                            d.cnt = '0;
                            if (!rx_s) begin
                                d.state   = ST_DATA;
                                d.seven   = (fmt == FMT_7P);
                                d.use_par = (fmt == FMT_7P) || (fmt == FMT_8P);
                                d.odd     = odd_par;
                                d.nbit    = '0;
                                d.acc     = 1'b0;
                                d.sh      = '0;
                            end else begin
                                d.state = ST_IDLE;
                            end
                        end else begin
                            d.cnt = q.cnt + 1'b1;
                        end
                    end
                end
                ST_DATA: begin
                    if (tick) begin
                        if (q.cnt == CNT_LAST) begin
                            d.cnt  = '0;
                            d.sh   = {rx_s, q.sh[DATA_W-1:1]};
                            d.acc  = q.acc ^ rx_s;
                            d.nbit = q.nbit + 1'b1;
                            if (q.nbit == (q.seven ? BIT_L7 : BIT_L8))
                                d.state = q.use_par ? ST_PAR : ST_STOP;
                        end else begin
                            d.cnt = q.cnt + 1'b1;
                        end
                    end
                end
                ST_PAR: begin
                    if (tick) begin
                        if (q.cnt == CNT_LAST) begin
                            d.cnt   = '0;
                            d.acc   = q.acc ^ rx_s;
                            d.state = ST_STOP;
                        end else begin
                            d.cnt = q.cnt + 1'b1;
                        end
                    end
                end
                ST_STOP: begin
                    if (tick) begin
                        if (q.cnt == CNT_LAST) begin
                            d.cnt       = '0;
                            d.vld       = 1'b1;
                            d.word.ferr = !rx_s;
                            d.word.perr = q.use_par & (q.acc ^ q.odd);
                            d.word.data = q.seven ? {1'b0, q.sh[DATA_W-1:1]} : q.sh;
                            d.state     = rx_s ? ST_IDLE : ST_HOLD;
                        end else begin
                            d.cnt = q.cnt + 1'b1;
                        end
                    end
                end
                ST_HOLD: begin
                    if (rx_s) d.state = ST_IDLE;
                end
                default: d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= SMP_RST;
        else        q <= d;
    end

    assign frame_vld  = q.vld;
    assign frame_word = q.word;
endmodule

// File: rtl/serrx_fifo.sv
module serrx_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         nonempty,
    output logic         half,
    output logic         full,
    output logic         ovr
);
    // DEPTH must be a power of two so the pointers wrap on their own.
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNTW = PW + 1;
    localparam logic [CNTW-1:0] CNT_FULL = CNTW'(DEPTH);
    localparam logic [CNTW-1:0] CNT_HALF = CNTW'(DEPTH/2);

    typedef struct packed {
        logic [PW-1:0]   wp;
        logic [PW-1:0]   rp;
        logic [CNTW-1:0] cnt;
        logic            ovr;
    } fifo_t;

    fifo_t q, d;
    logic [W-1:0] mem_q [DEPTH];
    logic [W-1:0] mem_d [DEPTH];
    logic do_pop, do_push;

    always_comb begin
        d       = q;
        mem_d   = mem_q;
        do_pop  = pop && (q.cnt != '0);
        do_push = push && ((q.cnt != CNT_FULL) || do_pop);
        if (clr) begin
            d = '0;
        end else begin
            if (do_pop) d.rp = q.rp + 1'b1;
            if (do_push) begin
                mem_d[q.wp] = din;
                d.wp        = q.wp + 1'b1;
            end
            case ({do_push, do_pop})
                2'b10:   d.cnt = q.cnt + 1'b1;
                2'b01:   d.cnt = q.cnt - 1'b1;
                default: d.cnt = q.cnt;
            endcase
            if (push && !do_push) d.ovr = 1'b1;
            else if (do_pop)      d.ovr = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            q     <= d;
            mem_q <= mem_d;
        end
    end

    assign nonempty = (q.cnt != '0);
    assign head     = nonempty ? mem_q[q.rp] : '0;
    assign half     = (q.cnt >= CNT_HALF);
    assign full     = (q.cnt == CNT_FULL);
    assign ovr      = q.ovr;
endmodule

// File: rtl/serial_rx_stat.sv
module serial_rx_stat
    import serrx_pkg::*;
#(
    parameter int OVS         = 16,
    parameter int DEPTH       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_in,
    input  logic        tick,
    input  logic [2:0]  fmt,
    input  logic        odd_par,
    input  logic        rx_en,
    input  logic        run,
    input  logic        fifo_clr,
    input  logic        rd_stb,
    output logic [9:0]  rd_word,
    output logic        stat_nonempty,
    output logic        stat_half,
    output logic        stat_ovr,
    output logic        rx_irq
);
    logic     rx_s;
    logic     active;
    logic     frame_vld;
    rx_word_t frame_word;
    logic     fifo_full;
    logic [WORD_W-1:0] head;

    assign active = rx_en & run;

    serrx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (rx_in),
        .q     (rx_s)
    );

    serrx_sampler #(.OVS(OVS)) u_smp (
        .clk        (clk),
        .rst_n      (rst_n),
        .active     (active),
        .tick       (tick),
        .rx_s       (rx_s),
        .fmt        (fmt),
        .odd_par    (odd_par),
        .frame_vld  (frame_vld),
        .frame_word (frame_word)
    );

    serrx_fifo #(.DEPTH(DEPTH), .W(WORD_W)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (fifo_clr),
        .push     (frame_vld),
        .din      (frame_word),
        .pop      (rd_stb),
        .head     (head),
        .nonempty (stat_nonempty),
        .half     (stat_half),
        .full     (fifo_full),
        .ovr      (stat_ovr)
    );

    assign rd_word = head;
    assign rx_irq  = stat_nonempty | stat_ovr;
endmodule

// File: rtl/serrx_checker.sv
module serrx_checker (
    input logic clk,
    input logic rst_n,
    input logic rx_en,
    input logic run,
    input logic fifo_clr,
    input logic rd_stb,
    input logic frame_vld,
    input logic fifo_full,
    input logic stat_nonempty,
    input logic stat_half,
    input logic stat_ovr
);
    AST_HALF_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        stat_half |-> stat_nonempty); // R8

    AST_OFF_NO_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_en && run) |=> !frame_vld); // R6

    AST_PUSH_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_vld && !fifo_clr) |=> stat_nonempty); // R7

    AST_OVR_ON_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_vld && fifo_full && !rd_stb && !fifo_clr) |=> stat_ovr); // R9

    AST_OVR_CLR_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && stat_nonempty && !frame_vld && !fifo_clr) |=> !stat_ovr); // R9

    AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_clr |=> (!stat_nonempty && !stat_ovr && !stat_half)); // R10
endmodule

bind serial_rx_stat serrx_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .rx_en         (rx_en),
    .run           (run),
    .fifo_clr      (fifo_clr),
    .rd_stb        (rd_stb),
    .frame_vld     (frame_vld),
    .fifo_full     (fifo_full),
    .stat_nonempty (stat_nonempty),
    .stat_half     (stat_half),
    .stat_ovr      (stat_ovr)
);

// File: tb/serial_rx_stat_bench.sv
module serial_rx_stat_bench;
    localparam int CLK_PERIOD = 10;
    localparam int OVS        = 16;
    localparam int DEPTH      = 16;
    localparam int BIT_CYC    = OVS * 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_in = 1'b1;
    logic       tick = 1'b0;
    logic [2:0] fmt = 3'd1;
    logic       odd_par = 1'b0;
    logic       rx_en = 1'b0;
    logic       run = 1'b0;
    logic       fifo_clr = 1'b0;
    logic       rd_stb = 1'b0;
    logic [9:0] rd_word;
    logic       stat_nonempty, stat_half, stat_ovr, rx_irq;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  auto_read = 1'b0;
    logic [9:0] exp_q [$];

    serial_rx_stat #(.OVS(OVS), .DEPTH(DEPTH), .SYNC_STAGES(2)) u_serial_rx_stat (
        .clk (clk), .rst_n (rst_n), .rx_in (rx_in), .tick (tick), .fmt (fmt),
        .odd_par (odd_par), .rx_en (rx_en), .run (run), .fifo_clr (fifo_clr),
        .rd_stb (rd_stb), .rd_word (rd_word), .stat_nonempty (stat_nonempty),
        .stat_half (stat_half), .stat_ovr (stat_ovr), .rx_irq (rx_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        forever begin
            @(negedge clk);
            tick = ~tick;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard whenever the design holds an entry.
    initial begin
        forever begin
            @(negedge clk);
            rd_stb = 1'b0;
            if (auto_read && stat_nonempty) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R7 unexpected entry", {22'd0, rd_word}, 32'd0);
                end else begin
                    logic [9:0] e;
                    e = exp_q.pop_front();
                    chk(rd_word == e, "R1/R2/R3/R5 scoreboard word", {22'd0, rd_word}, {22'd0, e});
                end
                rd_stb = 1'b1;
            end
        end
    end

    task automatic wait_bits(input int n);
        repeat (n * BIT_CYC) @(negedge clk);
    endtask

    // Driver: sends one frame and queues its expected read word.
    task automatic send(input logic [7:0] dat, input logic [2:0] f, input bit odd,
                        input bit bad_par, input bit stop_lvl, input bit store);
        logic [7:0] dm;
        bit         hp, p;
        int         nb;
        nb = (f == 3'd3) ? 7 : 8;
        hp = (f == 3'd3) || (f == 3'd7);
        dm = (f == 3'd3) ? {1'b0, dat[6:0]} : dat;
        p  = (^dm) ^ odd ^ bad_par;
        fmt     = f;
        odd_par = odd;
        if (store) exp_q.push_back({~stop_lvl, hp & bad_par, dm});
        rx_in = 1'b0;
        wait_bits(1);
        for (int i = 0; i < nb; i++) begin
            rx_in = dat[i];
            wait_bits(1);
        end
        if (hp) begin
            rx_in = p;
            wait_bits(1);
        end
        rx_in = stop_lvl;
        wait_bits(1);
        if (!stop_lvl) wait_bits(12);
        rx_in = 1'b1;
        wait_bits(2);
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state
        chk(stat_nonempty == 1'b0, "R7 reset nonempty", {31'd0, stat_nonempty}, 32'd0);
        chk(stat_half == 1'b0, "R8 reset half", {31'd0, stat_half}, 32'd0);
        chk(stat_ovr == 1'b0, "R9 reset ovr", {31'd0, stat_ovr}, 32'd0);
        chk(rx_irq == 1'b0, "R11 reset irq", {31'd0, rx_irq}, 32'd0);
        chk(rd_word == 10'd0, "R7 empty word", {22'd0, rd_word}, 32'd0);

        rx_en = 1'b1;
        run   = 1'b1;
        auto_read = 1'b1;
        wait_bits(2);

        // R1 plain 8-bit, R3 no parity flag
        send(8'h55, 3'd1, 1'b0, 1'b0, 1'b1, 1'b1);
        send(8'hA3, 3'd1, 1'b1, 1'b0, 1'b1, 1'b1);
        send(8'h00, 3'd1, 1'b0, 1'b0, 1'b1, 1'b1);
        send(8'hFF, 3'd1, 1'b0, 1'b0, 1'b1, 1'b1);
        // R1 unlisted code behaves as code 1
        send(8'h96, 3'd5, 1'b0, 1'b0, 1'b1, 1'b1);
        // R3 8 bits plus parity, even and odd, good and bad
        send(8'h3C, 3'd7, 1'b0, 1'b0, 1'b1, 1'b1);
        send(8'h3C, 3'd7, 1'b0, 1'b1, 1'b1, 1'b1);
        send(8'h81, 3'd7, 1'b1, 1'b0, 1'b1, 1'b1);
        send(8'h81, 3'd7, 1'b1, 1'b1, 1'b1, 1'b1);
        // R1 7 bits plus parity, bit 7 reads 0
        send(8'hD5, 3'd3, 1'b0, 1'b0, 1'b1, 1'b1);
        send(8'h2A, 3'd3, 1'b0, 1'b1, 1'b1, 1'b1);
        send(8'h7F, 3'd3, 1'b1, 1'b0, 1'b1, 1'b1);
        // R5 frame error, break, one entry per low period, then resume
        send(8'h5A, 3'd1, 1'b0, 1'b0, 1'b0, 1'b1);
        send(8'h00, 3'd1, 1'b0, 1'b0, 1'b0, 1'b1);
        send(8'h33, 3'd1, 1'b0, 1'b0, 1'b1, 1'b1);
        chk(exp_q.size() == 0, "R5 all entries seen", exp_q.size(), 32'd0);

        // R4 short glitch stores nothing
        auto_read = 1'b0;
        rx_in = 1'b0;
        repeat (8) @(negedge clk);
        rx_in = 1'b1;
        wait_bits(14);
        chk(stat_nonempty == 1'b0, "R4 glitch rejected", {31'd0, stat_nonempty}, 32'd0);

        // R6 receive gating
        rx_en = 1'b0;
        send(8'hC3, 3'd1, 1'b0, 1'b0, 1'b1, 1'b0);
        chk(stat_nonempty == 1'b0, "R6 rx_en low", {31'd0, stat_nonempty}, 32'd0);
        rx_en = 1'b1;
        run   = 1'b0;
        send(8'hC3, 3'd1, 1'b0, 1'b0, 1'b1, 1'b0);
        chk(stat_nonempty == 1'b0, "R6 run low", {31'd0, stat_nonempty}, 32'd0);
        run = 1'b1;
        wait_bits(1);

        // R8 half-full threshold, R9 overrun on full
        for (int i = 0; i < 7; i++) send(8'(8'h10 + i), 3'd1, 1'b0, 1'b0, 1'b1, 1'b1);
        chk(stat_half == 1'b0, "R8 seven entries", {31'd0, stat_half}, 32'd0);
        chk(rx_irq == 1'b1, "R11 irq on data", {31'd0, rx_irq}, 32'd1);
        send(8'h17, 3'd1, 1'b0, 1'b0, 1'b1, 1'b1);
        chk(stat_half == 1'b1, "R8 eight entries", {31'd0, stat_half}, 32'd1);
        for (int i = 8; i < DEPTH; i++) send(8'(8'h10 + i), 3'd1, 1'b0, 1'b0, 1'b1, 1'b1);
        chk(stat_ovr == 1'b0, "R9 full no ovr", {31'd0, stat_ovr}, 32'd0);
        send(8'hEE, 3'd1, 1'b0, 1'b0, 1'b1, 1'b0);
        chk(stat_ovr == 1'b1, "R9 ovr set", {31'd0, stat_ovr}, 32'd1);
        auto_read = 1'b1;
        repeat (2) @(negedge clk);
        chk(stat_ovr == 1'b0, "R9 ovr cleared by read", {31'd0, stat_ovr}, 32'd0);
        repeat (40) @(negedge clk);
        chk(exp_q.size() == 0, "R9 dropped char absent", exp_q.size(), 32'd0);
        chk(rx_irq == 1'b0, "R11 irq idle", {31'd0, rx_irq}, 32'd0);

        // R10 clear empties and drops overrun
        auto_read = 1'b0;
        for (int i = 0; i <= DEPTH; i++) send(8'(i), 3'd1, 1'b0, 1'b0, 1'b1, 1'b0);
        chk(stat_ovr == 1'b1, "R10 ovr before clear", {31'd0, stat_ovr}, 32'd1);
        fifo_clr = 1'b1;
        @(negedge clk);
        fifo_clr = 1'b0;
        chk(stat_nonempty == 1'b0, "R10 cleared empty", {31'd0, stat_nonempty}, 32'd0);
        chk(stat_ovr == 1'b0, "R10 cleared ovr", {31'd0, stat_ovr}, 32'd0);
        chk(stat_half == 1'b0, "R10 cleared half", {31'd0, stat_half}, 32'd0);
        chk(rd_word == 10'd0, "R7 word after clear", {22'd0, rd_word}, 32'd0);

        finish_run();
    end
endmodule